// File: doc/BRIEF.md
# Dual-Host Primary Interrupt Aggregator

This block sits in front of up to eight secondary interrupt units and tells each of two independent hosts which units want service. Every unit can drive a request toward host 1 and a separate request toward host 2. The block registers those requests and folds them into one primary status byte per host. It drives one active-low interrupt pin per host, low while that host's status byte is non-zero. Masking is left to the secondary units, so the primary stage has no enable bits. A host reads its status byte, then services the units whose bits are set.

Some units have only one request output. Build-time parameters list these units, and also list which of the eight slots have a unit fitted at all. A single-output unit's request appears in both hosts' status bytes. Slots with no unit always read as zero. A small register port gives read access to both status bytes. Through the same port a test register can be written, and its bits force requests into both hosts' status.

Top module: `pia_dual_host`

## Requirements
- R1: After the active-low synchronous reset, both interrupt pins are high, the read-valid strobe is low, both status bytes read 0x00 and the test register holds zero.
- R2: Status bit n of host 1 (read at offset 0x01) equals unit n's host-1 request as sampled at the previous clock edge.
- R3: For a unit with two outputs, status bit n of host 2 (read at offset 0x02) follows only that unit's host-2 request. Its host-1 request has no effect on host 2, and its host-2 request has no effect on host 1.
- R4: For a unit listed as single-output, its host-1 request input sets bit n in both status bytes, and its host-2 request input is ignored.
- R5: Bits for slots marked as unfitted read 0 in both status bytes, whatever their request inputs or test bits.
- R6: Each interrupt pin is low exactly when its host's status byte is non-zero. The pin follows the status byte with no further register stage.
- R7: A read strobe captures the addressed status into the read data at the next edge, and the read-valid strobe is high for that one cycle per strobe.
- R8: A read of any offset other than 0x01 and 0x02 returns 0x00. This includes offset 0x03, because the test register is write-only.
- R9: Writing a byte to offset 0x03 ORs its bits (for fitted slots) into both status bytes from the next edge on. They stay there until 0x00 is written to offset 0x03.
- R10: Writes to offsets 0x01 and 0x02 leave both status bytes and both interrupt pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_req_h1_i | input | NUM_UNITS | Per-unit request toward host 1 (the only output of single-output units) |
| unit_req_h2_i | input | NUM_UNITS | Per-unit request toward host 2 |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_addr_i | input | ADDR_W | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | One-cycle read-valid strobe |
| int1_n | output | 1 | Active-low interrupt to host 1 |
| int2_n | output | 1 | Active-low interrupt to host 2 |

## Verification
The hardest situation to reach from the ports is a disagreement between the two hosts' views of the same slot. This happens when a dual-output unit requests toward one host only, or when a single-output unit drives its unused second input. The stimulus applies such asymmetric request pairs and reads both status bytes for each pair. It also combines these pairs with forced test bits, because forced bits must appear in both views, and it compares the two interrupt pins against each other. Unfitted slots are driven high on both inputs and through the test register, to show that these bits never leak into either status byte.

// File: rtl/pia_pkg.sv
package pia_pkg;

  localparam int SLOT_W = 8;

  typedef logic [SLOT_W-1:0] slot_vec_t;

  typedef enum logic [7:0] {
    OFS_HOST1_STAT = 8'h01,
    OFS_HOST2_STAT = 8'h02,
    OFS_FORCE      = 8'h03
  } reg_ofs_e;

  // Host-2 source: single-output units contribute their one request.
  function automatic slot_vec_t host2_source(slot_vec_t req_h1, slot_vec_t req_h2,
                                             slot_vec_t single_out);
    return (req_h1 & single_out) | (req_h2 & ~single_out);
  endfunction

  // Status of one host: live requests plus forced bits, fitted slots only.
  function automatic slot_vec_t fold_status(slot_vec_t src, slot_vec_t force_bits,
                                            slot_vec_t fitted);
    return (src | force_bits) & fitted;
  endfunction

  function automatic logic any_set(slot_vec_t v);
    return |v;
  endfunction

endpackage

// File: rtl/pia_req_capture.sv
module pia_req_capture
  import pia_pkg::*;
#(
  parameter int NUM_UNITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] req_h1_i,
  input  logic [NUM_UNITS-1:0] req_h2_i,
  output slot_vec_t            req_h1_q,
  output slot_vec_t            req_h2_q
);

  logic [NUM_UNITS-1:0] h1_r;
  logic [NUM_UNITS-1:0] h2_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h1_r <= '0;
      h2_r <= '0;
    end else begin
      h1_r <= req_h1_i;
      h2_r <= req_h2_i;
    end
  end

  assign req_h1_q = slot_vec_t'(h1_r);
  assign req_h2_q = slot_vec_t'(h2_r);

  // R2: the captured host-1 byte is last cycle's input
  p_capture_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (req_h1_q == slot_vec_t'($past(req_h1_i))));

endmodule

// File: rtl/pia_line_fold.sv
module pia_line_fold
  import pia_pkg::*;
#(
  parameter slot_vec_t FITTED = 8'hFF
) (
  input  slot_vec_t src_i,
  input  slot_vec_t force_i,
  output slot_vec_t stat_o,
  output logic      irq_n_o
);

  slot_vec_t stat_w;

  assign stat_w  = fold_status(src_i, force_i, FITTED);
  assign stat_o  = stat_w;
  assign irq_n_o = ~any_set(stat_w);

  // R5: unfitted slots never appear (immediate check)
  always_comb begin
    p_unfitted_zero_r5: assert ((stat_o & ~FITTED) == '0);
  end

endmodule

// File: rtl/pia_reg_port.sv
module pia_reg_port
  import pia_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  slot_vec_t         stat_h1_i,
  input  slot_vec_t         stat_h2_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output slot_vec_t         force_q
);

  logic      hit_h1;
  logic      hit_h2;
  logic      hit_force;
  logic      force_wr_ev;
  slot_vec_t rd_mux;

  assign hit_h1      = (addr_i == ADDR_W'(OFS_HOST1_STAT));
  assign hit_h2      = (addr_i == ADDR_W'(OFS_HOST2_STAT));
  assign hit_force   = (addr_i == ADDR_W'(OFS_FORCE));
  assign force_wr_ev = wr_i & hit_force;

  always_comb begin
    rd_mux = '0;
    if (hit_h1)      rd_mux = stat_h1_i;
    else if (hit_h2) rd_mux = stat_h2_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      force_q  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_mux;
      if (force_wr_ev) force_q <= wdata_i;
    end
  end

  // R7: a read returns the addressed status seen at the strobe edge
  p_read_h1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && hit_h1) |=> (rvalid_o && rdata_o == $past(stat_h1_i)));
  p_read_h2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && hit_h2) |=> (rvalid_o && rdata_o == $past(stat_h2_i)));
  // R8: unmapped reads give zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !hit_h1 && !hit_h2) |=> (rvalid_o && rdata_o == 8'h00));
  // R10: status offsets do not alter the force register
  p_status_wr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !hit_force) |=> $stable(force_q));

endmodule

// File: rtl/pia_dual_host.sv
module pia_dual_host
  import pia_pkg::*;
#(
  parameter int                   NUM_UNITS  = 8,
  parameter int                   ADDR_W     = 8,
  parameter logic [NUM_UNITS-1:0] FIT_MASK   = 8'hEF,
  parameter logic [NUM_UNITS-1:0] SINGLE_OUT = 8'h40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] unit_req_h1_i,
  input  logic [NUM_UNITS-1:0] unit_req_h2_i,
  input  logic                 reg_rd_i,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [7:0]           reg_wdata_i,
  output logic [7:0]           reg_rdata_o,
  output logic                 reg_rvalid_o,
  output logic                 int1_n,
  output logic                 int2_n
);

  localparam int        NUM_HOSTS  = 2;
  localparam slot_vec_t FIT_EXT    = slot_vec_t'(FIT_MASK);
  localparam slot_vec_t SINGLE_EXT = slot_vec_t'(SINGLE_OUT);

  slot_vec_t req_h1_q;
  slot_vec_t req_h2_q;
  slot_vec_t force_q;
  slot_vec_t line_src  [NUM_HOSTS];
  slot_vec_t line_stat [NUM_HOSTS];
  logic      line_irq_n[NUM_HOSTS];

  pia_req_capture #(.NUM_UNITS(NUM_UNITS)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_h1_i (unit_req_h1_i),
    .req_h2_i (unit_req_h2_i),
    .req_h1_q (req_h1_q),
    .req_h2_q (req_h2_q)
  );

  for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_host
    if (h == 0) begin : g_src_h1
      assign line_src[h] = req_h1_q;
    end else begin : g_src_h2
      assign line_src[h] = host2_source(req_h1_q, req_h2_q, SINGLE_EXT);
    end
    pia_line_fold #(.FITTED(FIT_EXT)) u_fold (
      .src_i   (line_src[h]),
      .force_i (force_q),
      .stat_o  (line_stat[h]),
      .irq_n_o (line_irq_n[h])
    );
  end

  pia_reg_port #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_i      (reg_rd_i),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .stat_h1_i (line_stat[0]),
    .stat_h2_i (line_stat[1]),
    .rdata_o   (reg_rdata_o),
    .rvalid_o  (reg_rvalid_o),
    .force_q   (force_q)
  );

  assign int1_n = line_irq_n[0];
  assign int2_n = line_irq_n[1];

  // R4: single-output slots agree between the hosts
  p_single_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_stat[0] ^ line_stat[1]) & SINGLE_EXT) == '0);
  // R6: pins track whether the status byte is non-zero
  p_pin1_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int1_n == (line_stat[0] == '0));
  p_pin2_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int2_n == (line_stat[1] == '0));
  // R9: forced fitted bits show up in both hosts
  p_force_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((force_q & FIT_EXT & ~line_stat[0]) == '0) && ((force_q & FIT_EXT & ~line_stat[1]) == '0));
  // R1: reset leaves pins inactive and no read pending
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (int1_n && int2_n && !reg_rvalid_o));

endmodule

// File: tb/pia_dual_host_tb_top.sv
module pia_dual_host_tb_top;

  localparam logic [7:0] FIT  = 8'hEF;
  localparam logic [7:0] SGL  = 8'h40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req1 = '0, req2 = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       rvalid, int1_n, int2_n;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl_force = '0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t expq[$];

  always #2 clk = ~clk;

  pia_dual_host #(.FIT_MASK(FIT), .SINGLE_OUT(SGL)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .unit_req_h1_i(req1), .unit_req_h2_i(req2),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .reg_rvalid_o(rvalid),
    .int1_n(int1_n), .int2_n(int2_n)
  );

  // Bench model: per-slot view for each host.
  function automatic logic [7:0] model_stat(int host);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic bit_src;
      if (host == 1 || SGL[i]) bit_src = req1[i];
      else                     bit_src = req2[i];
      r[i] = FIT[i] ? (bit_src || mdl_force[i]) : 1'b0;
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_reqs(logic [7:0] a, logic [7:0] b);
    req1 = a; req2 = b;
    tick(2);
  endtask

  task automatic reg_write(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick(1);
    wr = 1'b0;
    if (a == 8'h03) mdl_force = d;
    tick(1);
  endtask

  task automatic reg_read(logic [7:0] a, string tag);
    exp_t e;
    if (a == 8'h01)      e.val = model_stat(1);
    else if (a == 8'h02) e.val = model_stat(2);
    else                 e.val = 8'h00;
    e.tag = tag;
    expq.push_back(e);
    addr = a; rd = 1'b1;
    tick(1);
    rd = 1'b0;
    tick(1);
    check(!rvalid, "R7 strobe one cycle", {7'd0, rvalid}, 8'h00);
  endtask

  task automatic check_pins(string tag);
    logic [7:0] s1, s2;
    s1 = model_stat(1); s2 = model_stat(2);
    check(int1_n == (s1 == 0), {tag, " int1_n"}, {7'd0, int1_n}, {7'd0, s1 == 0});
    check(int2_n == (s2 == 0), {tag, " int2_n"}, {7'd0, int2_n}, {7'd0, s2 == 0});
  endtask

  // Monitor: pops expected read data as the design returns it.
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R7 unexpected rvalid", rdata, 8'h00);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(rdata == e.val, e.tag, rdata, e.val);
      end
    end
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h01, 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check(int1_n && int2_n && !rvalid, "R1 reset idle", {5'd0, int1_n, int2_n, rvalid}, 8'h06);
    reg_read(8'h01, "R1 host1 after reset");
    reg_read(8'h02, "R1 host2 after reset");

    set_reqs(8'h05, 8'h00);
    reg_read(8'h01, "R2 host1 units 0,2");
    reg_read(8'h02, "R3 host2 untouched by host1 req");
    check_pins("R6 host1 only");

    set_reqs(8'h00, 8'h82);
    reg_read(8'h01, "R3 host1 untouched by host2 req");
    reg_read(8'h02, "R3 host2 units 1,7");
    check_pins("R6 host2 only");

    set_reqs(8'h40, 8'h00);
    reg_read(8'h01, "R4 single unit host1");
    reg_read(8'h02, "R4 single unit mirrored host2");
    set_reqs(8'h00, 8'h40);
    reg_read(8'h02, "R4 single unit second input ignored");
    check_pins("R4 pins idle");

    set_reqs(8'h10, 8'h10);
    reg_read(8'h01, "R5 unfitted host1");
    reg_read(8'h02, "R5 unfitted host2");
    check_pins("R5 pins idle");

    set_reqs(8'hA3, 8'h5C);
    reg_read(8'h01, "R2 mixed pattern host1");
    reg_read(8'h02, "R3 mixed pattern host2");
    check_pins("R6 mixed");

    reg_read(8'h00, "R8 offset 0x00");
    reg_read(8'h03, "R8 offset 0x03 write-only");
    reg_read(8'h7F, "R8 offset 0x7F");

    set_reqs(8'h00, 8'h00);
    reg_write(8'h01, 8'hFF);
    reg_write(8'h02, 8'hFF);
    reg_read(8'h01, "R10 host1 after status write");
    reg_read(8'h02, "R10 host2 after status write");
    check_pins("R10 pins idle");

    reg_write(8'h03, 8'h31);
    reg_read(8'h01, "R9 forced host1");
    reg_read(8'h02, "R9 forced host2");
    check_pins("R9 forced pins");
    set_reqs(8'h02, 8'h80);
    reg_read(8'h01, "R9 forced plus live host1");
    reg_read(8'h02, "R9 forced plus live host2");
    set_reqs(8'h00, 8'h00);
    reg_write(8'h03, 8'h10);
    reg_read(8'h01, "R9 forced unfitted host1");
    check_pins("R9 unfitted force");
    reg_write(8'h03, 8'h00);
    reg_read(8'h02, "R9 cleared host2");
    check_pins("R9 cleared pins");

    reg_write(8'h03, 8'h01);
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    mdl_force = '0;
    tick(1);
    check(int1_n && int2_n, "R1 reset clears force", {6'd0, int1_n, int2_n}, 8'h03);
    reg_read(8'h01, "R1 host1 after mid-run reset");

    tick(4);
    check(expq.size() == 0, "R7 all reads answered", 8'(expq.size()), 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule